// File: doc/BRIEF.md
# Indirect PHY Register Sequencer

This block lets on-chip logic read and write a 16-bit register space inside a PHY that has no address bus of its own. The PHY is reached through one 20-bit control word and one 17-bit status word. Every access is a chain of four-phase handshakes. The sequencer raises one capture or strobe bit, waits until the PHY acknowledges, drops the bit and waits until the acknowledge goes away. Only then does it move on to the next phase.

A client presents an address, write data and a direction together with a one-cycle request while the block is idle. A write passes through an address phase, a data phase and a write-strobe phase. A read passes through an address phase and a read-strobe phase, and the read data is captured from the status word. Each acknowledge wait looks at the synchronized acknowledge a bounded number of times, spaced by a fixed interval. When the expected level never shows, the access is abandoned and reported as a timeout. A one-cycle done pulse ends every access, with the error flag set alongside it on a timeout.

Top module: `phy_reg_seq`

## Requirements
- R1: Control word layout: bits 15:0 carry the address or the data, bit 16 is capture-address, bit 17 is capture-data, bit 18 is the write strobe and bit 19 is the read strobe. At most one of bits 19:16 is ever set. The status word carries the acknowledge in bit 16 and the read data in bits 15:0.
- R2: The address phase drives the address alone for one cycle. It then drives the address with capture-address set and waits for acknowledge high. It then drives the address without capture-address and waits for acknowledge low.
- R3: After the address phase, a write drives the data alone for one cycle. It then drives the data with capture-data set and waits for acknowledge high. It then drives the data alone and waits for acknowledge low.
- R4: A write then drives the write strobe with a zero field and waits for acknowledge high. It then drives the data alone and waits for acknowledge low, and the control word returns to zero.
- R5: After the address phase, a read drives the read strobe with a zero field and waits for acknowledge high. It captures status bits 15:0 in the cycle of that acknowledge, then drives the control word to zero and waits for acknowledge low. The read data output changes only on such a capture.
- R6: The acknowledge passes through a two-flop synchronizer. In each wait, the k-th sample (k = 0..9) is taken SAMPLE_GAP-1+k*SAMPLE_GAP cycles after the wait state is entered. An acknowledge level reaching the synchronizer input in cycle c can first be seen by a sample two cycles later.
- R7: If none of the 10 samples of a wait shows the expected level, the control word goes to zero, done and error pulse together for one cycle, and the block returns to idle and accepts the next request normally.
- R8: On a successful access, done pulses for exactly one cycle with error low, in the cycle after the last acknowledge-low sample, while the control word is zero.
- R9: A request is taken only while idle. A request raised during an access, including its done cycle, is ignored: it starts no access and changes no captured address or data.
- R10: During reset and right after it, the control word, done, error and read data are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Access request, taken only while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Data from the last completed read |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_err | output | 1 | High with done when an acknowledge wait timed out |
| phy_ctrl | output | 20 | Control word toward the PHY |
| phy_stat | input | 17 | Status word from the PHY: acknowledge in bit 16, read data in 15:0 |

## Verification
A wrong sequencer state shows at once as a wrong control word. That can be a field that differs from the latched address or data, a missing or extra strobe, or a phase that is skipped. The cycle-accurate model catches it in the very cycle the state is entered. An error in the poll timer or in the synchronizer depth moves the instant a wait ends by a whole sample interval. The bench checks this through the length of the capture-address pulse for acknowledge latencies that sit just on either side of a sample. A wrong idle guard shows as an extra access or an extra done pulse after a request that should have been ignored.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR_SET,
    ST_ADDR_CAP,
    ST_ADDR_REL,
    ST_DATA_SET,
    ST_DATA_CAP,
    ST_DATA_REL,
    ST_WR_STB,
    ST_WR_REL,
    ST_RD_STB,
    ST_RD_REL,
    ST_DONE
  } seq_state_e;

  // strobe positions above the field, counted from the field width
  localparam int unsigned OFS_CAP_ADDR = 0;
  localparam int unsigned OFS_CAP_DATA = 1;
  localparam int unsigned OFS_WR_STB   = 2;
  localparam int unsigned OFS_RD_STB   = 3;
  localparam int unsigned NUM_STROBES  = 4;

endpackage

// File: rtl/phy_seq_rst_sync.sv
module phy_seq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/phy_seq_sync.sv
module phy_seq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= '0;
          else        stage_q[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[i] <= '0;
          else        stage_q[i] <= stage_q[i-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/phy_seq_poll.sv
module phy_seq_poll #(
  parameter int unsigned SAMPLE_GAP = 200,
  parameter int unsigned MAX_POLLS  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic expect_lvl,
  input  logic ack,
  output logic hit,
  output logic expire
);

  localparam int unsigned GAP_W  = (SAMPLE_GAP > 1) ? $clog2(SAMPLE_GAP) : 1;
  localparam int unsigned POLL_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [GAP_W-1:0]  GAP_LAST  = GAP_W'(SAMPLE_GAP - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);

  logic [GAP_W-1:0]  gap_q, gap_d;
  logic [POLL_W-1:0] poll_q, poll_d;
  logic              sample;

  always_comb begin
    sample = run && (gap_q == GAP_LAST);
    hit    = sample && (ack == expect_lvl);
    expire = sample && (ack != expect_lvl) && (poll_q == POLL_LAST);
    gap_d  = gap_q;
    poll_d = poll_q;
    if (!run || hit || expire) begin
      gap_d  = '0;
      poll_d = '0;
    end else if (sample) begin
      gap_d  = '0;
      poll_d = poll_q + 1'b1;
    end else begin
      gap_d  = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      poll_q <= '0;
    end else begin
      gap_q  <= gap_d;
      poll_q <= poll_d;
    end
  end

endmodule

// File: rtl/phy_reg_seq.sv
module phy_reg_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 200,
  parameter int unsigned SAMPLE_GAP = CLK_MHZ,
  parameter int unsigned MAX_POLLS  = 10,
  parameter int unsigned FIELD_W    = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic                           req_write,
  input  logic [FIELD_W-1:0]             req_addr,
  input  logic [FIELD_W-1:0]             req_wdata,
  output logic [FIELD_W-1:0]             rsp_rdata,
  output logic                           rsp_done,
  output logic                           rsp_err,
  output logic [FIELD_W+NUM_STROBES-1:0] phy_ctrl,
  input  logic [FIELD_W:0]               phy_stat
);

  localparam int unsigned CTRL_W = FIELD_W + NUM_STROBES;

  logic              rst_i_n;
  logic              ack_s;
  seq_state_e        st_q, st_d;
  logic              wr_q;
  logic [FIELD_W-1:0] addr_q, data_q, rdata_q;
  logic              err_q;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              poll_run, poll_expect, poll_hit, poll_expire;
  logic              load_req, cap_rd;
  logic [FIELD_W-1:0] addr_src, data_src;

  phy_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_i_n)
  );

  phy_seq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .d     (phy_stat[FIELD_W]),
    .q     (ack_s)
  );

  phy_seq_poll #(.SAMPLE_GAP(SAMPLE_GAP), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .run        (poll_run),
    .expect_lvl (poll_expect),
    .ack        (ack_s),
    .hit        (poll_hit),
    .expire     (poll_expire)
  );

  // wait-phase decode
  always_comb begin
    poll_run    = 1'b0;
    poll_expect = 1'b0;
    unique case (st_q)
      ST_ADDR_CAP, ST_DATA_CAP, ST_WR_STB, ST_RD_STB: begin
        poll_run    = 1'b1;
        poll_expect = 1'b1;
      end
      ST_ADDR_REL, ST_DATA_REL, ST_WR_REL, ST_RD_REL: poll_run = 1'b1;
      default: ;
    endcase
  end

  // next state
  always_comb begin
    load_req = (st_q == ST_IDLE) && req_valid;
    cap_rd   = (st_q == ST_RD_STB) && poll_hit;
    st_d     = st_q;
    unique case (st_q)
      ST_IDLE:     if (req_valid) st_d = ST_ADDR_SET;
      ST_ADDR_SET: st_d = ST_ADDR_CAP;
      ST_ADDR_CAP: if (poll_hit) st_d = ST_ADDR_REL;
      ST_ADDR_REL: if (poll_hit) st_d = wr_q ? ST_DATA_SET : ST_RD_STB;
      ST_DATA_SET: st_d = ST_DATA_CAP;
      ST_DATA_CAP: if (poll_hit) st_d = ST_DATA_REL;
      ST_DATA_REL: if (poll_hit) st_d = ST_WR_STB;
      ST_WR_STB:   if (poll_hit) st_d = ST_WR_REL;
      ST_WR_REL:   if (poll_hit) st_d = ST_DONE;
      ST_RD_STB:   if (poll_hit) st_d = ST_RD_REL;
      ST_RD_REL:   if (poll_hit) st_d = ST_DONE;
      default:     st_d = ST_IDLE;
    endcase
    if (poll_expire) st_d = ST_DONE;
  end

  // control word for the state being entered
  always_comb begin
    addr_src = load_req ? req_addr  : addr_q;
    data_src = load_req ? req_wdata : data_q;
    ctrl_d   = '0;
    unique case (st_d)
      ST_ADDR_SET, ST_ADDR_REL: ctrl_d[FIELD_W-1:0] = addr_src;
      ST_ADDR_CAP: begin
        ctrl_d[FIELD_W-1:0]             = addr_src;
        ctrl_d[FIELD_W + OFS_CAP_ADDR]  = 1'b1;
      end
      ST_DATA_SET, ST_DATA_REL, ST_WR_REL: ctrl_d[FIELD_W-1:0] = data_src;
      ST_DATA_CAP: begin
        ctrl_d[FIELD_W-1:0]             = data_src;
        ctrl_d[FIELD_W + OFS_CAP_DATA]  = 1'b1;
      end
      ST_WR_STB: ctrl_d[FIELD_W + OFS_WR_STB] = 1'b1;
      ST_RD_STB: ctrl_d[FIELD_W + OFS_RD_STB] = 1'b1;
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      ctrl_q <= '0;
    end else begin
      st_q   <= st_d;
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (load_req) begin
      wr_q   <= req_write;
      addr_q <= req_addr;
      data_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)     rdata_q <= '0;
    else if (cap_rd)  rdata_q <= phy_stat[FIELD_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)                      err_q <= 1'b0;
    else if (poll_expire || load_req)  err_q <= poll_expire;
  end

  assign phy_ctrl  = ctrl_q;
  assign rsp_rdata = rdata_q;
  assign rsp_done  = (st_q == ST_DONE);
  assign rsp_err   = (st_q == ST_DONE) && err_q;

endmodule

// File: rtl/phy_reg_seq_chk.sv
module phy_reg_seq_chk #(
  parameter int unsigned FIELD_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [FIELD_W+3:0]   phy_ctrl,
  input logic                 rsp_done,
  input logic                 rsp_err,
  input logic [FIELD_W-1:0]   rsp_rdata,
  input logic                 busy,
  input logic [FIELD_W-1:0]   addr_q,
  input logic [FIELD_W-1:0]   data_q
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_ctrl[FIELD_W+3:FIELD_W])); // R1

  AST_CAP_ADDR_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_ctrl[FIELD_W]) |->
      ($past(phy_ctrl[FIELD_W-1:0]) == phy_ctrl[FIELD_W-1:0]) &&
      ($past(phy_ctrl[FIELD_W+3:FIELD_W]) == 4'b0000)); // R2

  AST_CAP_DATA_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_ctrl[FIELD_W+1]) |->
      ($past(phy_ctrl[FIELD_W-1:0]) == phy_ctrl[FIELD_W-1:0]) &&
      ($past(phy_ctrl[FIELD_W+3:FIELD_W]) == 4'b0000)); // R3

  AST_WR_STB_BARE: assert property (@(posedge clk) disable iff (!rst_n)
    phy_ctrl[FIELD_W+2] |-> (phy_ctrl[FIELD_W-1:0] == '0)); // R4

  AST_RD_STB_BARE: assert property (@(posedge clk) disable iff (!rst_n)
    phy_ctrl[FIELD_W+3] |-> (phy_ctrl[FIELD_W-1:0] == '0)); // R5

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> $past(phy_ctrl[FIELD_W+3])); // R5

  AST_ERR_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_done); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R8

  AST_DONE_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (phy_ctrl == '0)); // R8

  AST_BUSY_HOLDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(data_q))); // R9

endmodule

bind phy_reg_seq phy_reg_seq_chk #(.FIELD_W(FIELD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phy_ctrl  (phy_ctrl),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .busy      (st_q != phy_seq_pkg::ST_IDLE),
  .addr_q    (addr_q),
  .data_q    (data_q)
);

// File: tb/tb_phy_reg_seq.sv
`timescale 1ns/1ps
module tb_phy_reg_seq;

  localparam int GAP  = 6;
  localparam int MAXP = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr, req_wdata;
  logic [15:0] rsp_rdata;
  logic        rsp_done, rsp_err;
  logic [19:0] phy_ctrl;
  logic [16:0] phy_stat;

  always #2.5 clk = ~clk;

  phy_reg_seq #(.SAMPLE_GAP(GAP), .MAX_POLLS(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  task automatic check(string tag, string what, int got, int exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s got %0h expected %0h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // ---------------- behavioural PHY ----------------
  logic        phy_ack;
  logic [15:0] stat_data;
  logic [15:0] mem [16];
  logic [15:0] cur_addr, cur_data;
  int          phy_mode;   // 0 normal, 1 never acks, 2 never releases ack
  int          lat;
  int          dly;
  assign phy_stat = {phy_ack, stat_data};

  always @(negedge clk) begin
    if (phy_ctrl[19:16] != 4'b0 && !phy_ack) begin
      if (phy_mode != 1) begin
        if (dly >= lat) begin
          phy_ack = 1'b1;
          dly = 0;
          if (phy_ctrl[16]) cur_addr = phy_ctrl[15:0];
          if (phy_ctrl[17]) cur_data = phy_ctrl[15:0];
          if (phy_ctrl[18]) mem[cur_addr[3:0]] = cur_data;
          if (phy_ctrl[19]) stat_data = mem[cur_addr[3:0]];
        end else dly++;
      end
    end else if (phy_ctrl[19:16] == 4'b0 && phy_ack) begin
      if (phy_mode != 2) begin
        if (dly >= lat) begin phy_ack = 1'b0; dly = 0; end
        else dly++;
      end
    end else dly = 0;
  end

  // ---------------- reference model ----------------
  int    q_ctrl[$];
  int    q_kind[$];   // 0 drive one cycle, 1 wait ack high, 2 wait ack low
  int    q_cap[$];
  string q_tag[$];
  int    m_ctrl, m_done, m_err, m_rdata, m_cnt, rel;
  string m_tag;
  bit    s1, s2, ack_now;
  int    done_cnt;

  task automatic push(int c, int k, int cap, string t);
    q_ctrl.push_back(c); q_kind.push_back(k); q_cap.push_back(cap); q_tag.push_back(t);
  endtask

  task automatic advance();
    void'(q_ctrl.pop_front()); void'(q_kind.pop_front());
    void'(q_cap.pop_front());  void'(q_tag.pop_front());
    m_cnt = 0;
    if (q_ctrl.size() == 0) begin
      m_done = 1; m_err = 0; m_ctrl = 0; m_tag = "R8";
    end else begin
      m_ctrl = q_ctrl[0]; m_tag = q_tag[0];
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rel = 0; s1 = 0; s2 = 0; m_ctrl = 0; m_done = 0; m_err = 0; m_rdata = 0;
      m_cnt = 0; m_tag = "R10";
      q_ctrl.delete(); q_kind.delete(); q_cap.delete(); q_tag.delete();
    end else if (rel < 2) begin
      rel++;
    end else begin
      ack_now = s2;
      s2 = s1;
      s1 = phy_ack;
      if (m_done != 0) begin
        m_done = 0; m_err = 0; m_ctrl = 0; m_tag = "R1";
      end else if (q_ctrl.size() == 0) begin
        if (req_valid) begin
          push(int'(req_addr), 0, 0, "R2");
          push(int'(req_addr) | 32'h10000, 1, 0, "R2");
          push(int'(req_addr), 2, 0, "R2");
          if (req_write) begin
            push(int'(req_wdata), 0, 0, "R3");
            push(int'(req_wdata) | 32'h20000, 1, 0, "R3");
            push(int'(req_wdata), 2, 0, "R3");
            push(32'h40000, 1, 0, "R4");
            push(int'(req_wdata), 2, 0, "R4");
          end else begin
            push(32'h80000, 1, 1, "R5");
            push(0, 2, 0, "R5");
          end
          m_ctrl = q_ctrl[0]; m_tag = q_tag[0]; m_cnt = 0;
        end
      end else if (q_kind[0] == 0) begin
        advance();
      end else begin
        if ((m_cnt % GAP) == GAP - 1) begin
          if (ack_now == (q_kind[0] == 1)) begin
            if (q_cap[0] != 0) m_rdata = int'(phy_stat[15:0]);
            advance();
          end else if ((m_cnt / GAP) == MAXP - 1) begin
            q_ctrl.delete(); q_kind.delete(); q_cap.delete(); q_tag.delete();
            m_done = 1; m_err = 1; m_ctrl = 0; m_tag = "R7";
          end else m_cnt++;
        end else m_cnt++;
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  bit mon_en = 0;
  int capa_cycles, multi_strobe;
  always @(negedge clk) begin
    if (mon_en) begin
      check(m_tag, "phy_ctrl", int'(phy_ctrl), m_ctrl);
      check(m_err != 0 ? "R7" : "R8", "rsp_done", int'(rsp_done), m_done);
      check("R7", "rsp_err", int'(rsp_err), (m_done != 0 && m_err != 0) ? 1 : 0);
      check("R5", "rsp_rdata", int'(rsp_rdata), m_rdata);
      if (phy_ctrl[16]) capa_cycles++;
      if ($countones(phy_ctrl[19:16]) > 1) multi_strobe++;
      if (rsp_done) done_cnt++;
    end
  end

  // ---------------- stimulus ----------------
  bit last_err;

  task automatic wait_done();
    do @(negedge clk); while (!rsp_done);
    last_err = rsp_err;
  endtask

  task automatic access(bit w, logic [15:0] a, logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired, run hung");
    summary();
  end

  initial begin
    int dc;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    phy_ack = 1'b0; stat_data = '0; phy_mode = 0; lat = 0; dly = 0;
    cur_addr = '0; cur_data = '0; done_cnt = 0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    idle(3);
    mon_en = 1;
    // R10 reset values
    check("R10", "ctrl in reset", int'(phy_ctrl), 0);
    check("R10", "done/err in reset", int'({rsp_done, rsp_err}), 0);
    check("R10", "rdata in reset", int'(rsp_rdata), 0);
    rst_n = 1'b1;
    idle(4);
    check("R10", "ctrl after reset", int'(phy_ctrl), 0);

    // R6: ack latency just early enough for the first sample
    lat = 3; capa_cycles = 0;
    access(1'b1, 16'h0003, 16'hBEEF);
    check("R6", "capture-address cycles lat3", capa_cycles, GAP);
    check("R8", "write error flag", int'(last_err), 0);
    check("R4", "PHY register written", int'(mem[3]), 16'hBEEF);

    // R6: one cycle later misses the first sample
    lat = 4; capa_cycles = 0;
    access(1'b1, 16'h0005, 16'h1234);
    check("R6", "capture-address cycles lat4", capa_cycles, 2 * GAP);
    check("R3", "PHY captured data", int'(cur_data), 16'h1234);
    check("R2", "PHY captured address", int'(cur_addr), 16'h0005);

    // R5 reads with different latencies
    lat = 0;
    access(1'b0, 16'h0003, 16'h0);
    check("R5", "read back reg 3", int'(rsp_rdata), 16'hBEEF);
    lat = 9;
    access(1'b0, 16'h0005, 16'h0);
    check("R5", "read back reg 5", int'(rsp_rdata), 16'h1234);
    idle(10);
    check("R5", "rdata held while idle", int'(rsp_rdata), 16'h1234);

    // R9: request during an access is ignored
    lat = 2; dc = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0007; req_wdata = 16'hA5A5;
    @(negedge clk);
    req_valid = 1'b0;
    idle(15);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0009; req_wdata = 16'h1111;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    idle(40);
    check("R9", "one done for two requests", done_cnt - dc, 1);
    check("R9", "busy request not written", int'(mem[9]), 0);
    check("R9", "first request written", int'(mem[7]), 16'hA5A5);

    // R9: request held through the done cycle starts nothing more
    dc = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h000A; req_wdata = 16'h2222;
    wait_done();
    req_valid = 1'b0;
    idle(40);
    check("R9", "held request gives one access", done_cnt - dc, 1);
    check("R1", "no simultaneous strobes", multi_strobe, 0);

    // R7: PHY never acknowledges
    phy_mode = 1; capa_cycles = 0;
    access(1'b1, 16'h0001, 16'h5555);
    check("R7", "timeout error", int'(last_err), 1);
    check("R7", "capture-address cycles to timeout", capa_cycles, MAXP * GAP);
    check("R7", "ctrl zero after timeout", int'(phy_ctrl), 0);

    // R7: PHY never drops acknowledge
    phy_mode = 2;
    access(1'b0, 16'h0003, 16'h0);
    check("R7", "stuck ack timeout", int'(last_err), 1);
    phy_mode = 0; lat = 0;
    idle(5);
    phy_ack = 1'b0;
    idle(5);

    // R7: recovery after timeouts
    access(1'b0, 16'h000A, 16'h0);
    check("R7", "access after timeout ok", int'(last_err), 0);
    check("R5", "read back reg 10", int'(rsp_rdata), 16'h2222);

    idle(10);
    summary();
  end

endmodule